// File: doc/BRIEF.md
# Pulse-Aligned Seconds/Ticks Timekeeper

This block keeps absolute time as two counters: a ticks counter that advances once per clock and a seconds counter that advances each time the ticks counter wraps. The wrap point is a ticks-per-second value set by software. Software places new seconds and ticks values in staging registers and chooses how they are applied. They can be loaded on the clock after the seconds write, or held until the next edge of an external pulse-per-second input. The polarity of that edge is selectable.

Independently of any pending load, every selected pulse edge captures the running time into a second pair of registers. Software uses them to relate the pulse to local time. The pulse input is brought into the clock domain by a two-flop synchronizer, and edges are detected on the synchronized signal.

Load sequencing is a small state machine with three states. `TK_IDLE` means nothing is pending. `TK_WAIT_PULSE` means a load is armed and waits for the selected edge. `TK_LOAD_NOW` means a load applies on the next clock. Its transitions are:
- arm_wait: any state to `TK_WAIT_PULSE`, on a seconds write while the immediate bit is 0.
- arm_now: any state to `TK_LOAD_NOW`, on a seconds write while the immediate bit is 1.
- pulse_apply: `TK_WAIT_PULSE` to `TK_IDLE`, on a selected edge.
- now_apply: `TK_LOAD_NOW` to `TK_IDLE`, on the next clock.

Top module: `pps_timekeeper`

## Requirements
- R1: After reset both running counters and both capture registers read 0, the immediate bit and edge-select bit are 0, and the wrap value is 100000000, so the ticks counter simply counts up from 0.
- R2: Without a load, ticks advances by 1 per clock. When ticks is at or above wrap-1, the next clock sets ticks to 0 and adds 1 to seconds. A wrap value of 1 makes seconds advance every clock with ticks held at 0.
- R3: Write index 0 stages seconds and arms a load, index 1 stages ticks, index 2 bit 0 is the edge select, index 3 bit 0 is the immediate bit, and index 4 is the wrap value. Writes to indices 5 to 7 change nothing observable.
- R4: With the immediate bit at 1, a seconds write sampled at clock edge E makes the outputs show the staged seconds and ticks after edge E+1.
- R5: With the immediate bit at 0, an armed load stays pending through any number of clocks and through unselected pulse edges.
- R6: Edge select 0 chooses the falling edge of the pulse input and 1 chooses the rising edge.
- R7: A pulse input change that is sampled at clock edge E0 acts at clock edge E0+2, because of two synchronizer flops followed by edge detection.
- R8: At every selected pulse edge the capture registers take the running time as it was just before that clock edge. Unselected edges leave the capture registers unchanged.
- R9: A load replaces counting in the cycle it applies, and it is consumed. A later selected edge with no new seconds write only captures and does not reload.
- R10: A second seconds write while a load is pending replaces the staged seconds, and the load that follows uses the newer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Settings write strobe |
| cfg_idx | input | 3 | Settings index |
| cfg_data | input | 32 | Settings write data |
| pps_in | input | 1 | Asynchronous pulse-per-second input |
| now_sec | output | 32 | Running seconds |
| now_tick | output | 32 | Running ticks within the second |
| cap_sec | output | 32 | Seconds captured at the last selected pulse edge |
| cap_tick | output | 32 | Ticks captured at the last selected pulse edge |

## Verification
The checker observes every cycle. It confirms the single-step increment and the wrap arithmetic against the live wrap value. It confirms that an applied load produces exactly the staged pair on the following cycle and is never applied twice in a row. It confirms that an immediate-mode seconds write triggers a load, and that the capture registers hold still on cycles without a selected edge.

Some properties depend on the input history, and only the bench scenarios can show them. These are the exact three-clock latency from a pulse change to its effect, the choice of polarity, and a load pending across an unselected edge. Others depend on software sequences: replacing an armed value, consuming a load so that a later edge only captures, and ignoring unused indices. The bench compares every output against arithmetic time derived from the last load point.

// File: rtl/tk_pkg.sv
package tk_pkg;
    localparam int unsigned TK_IDX_W = 3;

    localparam logic [TK_IDX_W-1:0] IDX_SEC   = 3'd0;
    localparam logic [TK_IDX_W-1:0] IDX_TICK  = 3'd1;
    localparam logic [TK_IDX_W-1:0] IDX_EDGE  = 3'd2;
    localparam logic [TK_IDX_W-1:0] IDX_IMM   = 3'd3;
    localparam logic [TK_IDX_W-1:0] IDX_WRAP  = 3'd4;

    typedef enum logic [1:0] {
        TK_IDLE       = 2'd0,
        TK_WAIT_PULSE = 2'd1,
        TK_LOAD_NOW   = 2'd2
    } tk_state_e;
endpackage

// File: rtl/tk_pulse_edge.sv
module tk_pulse_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_async,
    input  logic rise_sel,
    output logic edge_evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   cur;

    assign cur = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pulse_async};
            last_q <= cur;
        end
    end

    always_comb begin
        if (rise_sel) edge_evt = cur & ~last_q;
        else          edge_evt = ~cur & last_q;
    end
endmodule

// File: rtl/tk_cfg_bank.sv
module tk_cfg_bank
    import tk_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned WRAP_INIT = 100000000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [TK_IDX_W-1:0] cfg_idx,
    input  logic [DATA_W-1:0]   cfg_data,
    output logic [DATA_W-1:0]   sec_stage,
    output logic [DATA_W-1:0]   tick_stage,
    output logic                rise_sel,
    output logic                imm_q,
    output logic [DATA_W-1:0]   wrap_q,
    output logic                sec_wr
);
    localparam logic [DATA_W-1:0] WRAP_RST = DATA_W'(WRAP_INIT);

    assign sec_wr = cfg_wr && (cfg_idx == IDX_SEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_stage  <= '0;
            tick_stage <= '0;
            rise_sel   <= 1'b0;
            imm_q      <= 1'b0;
            wrap_q     <= WRAP_RST;
        end else if (cfg_wr) begin
            unique case (cfg_idx)
                IDX_SEC:  sec_stage  <= cfg_data;
                IDX_TICK: tick_stage <= cfg_data;
                IDX_EDGE: rise_sel   <= cfg_data[0];
                IDX_IMM:  imm_q      <= cfg_data[0];
                IDX_WRAP: wrap_q     <= cfg_data;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/tk_load_ctrl.sv
module tk_load_ctrl
    import tk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sec_wr,
    input  logic      imm_q,
    input  logic      edge_evt,
    output logic      load_go,
    output tk_state_e state_q
);
    tk_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= TK_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (sec_wr) begin
            state_d = imm_q ? TK_LOAD_NOW : TK_WAIT_PULSE;
        end else begin
            unique case (state_q)
                TK_IDLE:       state_d = TK_IDLE;
                TK_WAIT_PULSE: if (edge_evt) state_d = TK_IDLE;
                TK_LOAD_NOW:   state_d = TK_IDLE;
                default:       state_d = TK_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            TK_IDLE:       load_go = 1'b0;
            TK_WAIT_PULSE: load_go = edge_evt;
            TK_LOAD_NOW:   load_go = 1'b1;
            default:       load_go = 1'b0;
        endcase
    end
endmodule

// File: rtl/pps_timekeeper.sv
module pps_timekeeper
    import tk_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned WRAP_INIT = 100000000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [TK_IDX_W-1:0] cfg_idx,
    input  logic [DATA_W-1:0]   cfg_data,
    input  logic                pps_in,
    output logic [DATA_W-1:0]   now_sec,
    output logic [DATA_W-1:0]   now_tick,
    output logic [DATA_W-1:0]   cap_sec,
    output logic [DATA_W-1:0]   cap_tick
);
    logic [DATA_W-1:0] sec_stage, tick_stage, wrap_q;
    logic              rise_sel, imm_q, sec_wr, edge_evt, load_go;
    tk_state_e         state_q;

    tk_cfg_bank #(.DATA_W(DATA_W), .WRAP_INIT(WRAP_INIT)) u_cfg (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .sec_stage(sec_stage), .tick_stage(tick_stage),
        .rise_sel(rise_sel), .imm_q(imm_q), .wrap_q(wrap_q), .sec_wr(sec_wr)
    );

    tk_pulse_edge #(.SYNC_STAGES(2)) u_edge (
        .clk(clk), .rst(rst), .pulse_async(pps_in),
        .rise_sel(rise_sel), .edge_evt(edge_evt)
    );

    tk_load_ctrl u_ctrl (
        .clk(clk), .rst(rst), .sec_wr(sec_wr), .imm_q(imm_q),
        .edge_evt(edge_evt), .load_go(load_go), .state_q(state_q)
    );

    logic at_wrap;
    assign at_wrap = (now_tick >= wrap_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            now_sec  <= '0;
            now_tick <= '0;
        end else if (load_go) begin
            now_sec  <= sec_stage;
            now_tick <= tick_stage;
        end else if (at_wrap) begin
            now_sec  <= now_sec + 1'b1;
            now_tick <= '0;
        end else begin
            now_tick <= now_tick + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_sec  <= '0;
            cap_tick <= '0;
        end else if (edge_evt) begin
            cap_sec  <= now_sec;
            cap_tick <= now_tick;
        end
    end
endmodule

// File: rtl/tk_checker.sv
module tk_checker #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              load_go,
    input logic              edge_evt,
    input logic              sec_wr,
    input logic              imm_q,
    input logic [DATA_W-1:0] wrap_q,
    input logic [DATA_W-1:0] sec_stage,
    input logic [DATA_W-1:0] tick_stage,
    input logic [DATA_W-1:0] now_sec,
    input logic [DATA_W-1:0] now_tick,
    input logic [DATA_W-1:0] cap_sec,
    input logic [DATA_W-1:0] cap_tick
);
    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_go && wrap_q != '0 && now_tick < wrap_q - 1'b1)
        |=> (now_tick == $past(now_tick) + 1'b1 && now_sec == $past(now_sec)));

    // R2
    tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_go && wrap_q != '0 && now_tick == wrap_q - 1'b1)
        |=> (now_tick == '0 && now_sec == $past(now_sec) + 1'b1));

    // R9
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        load_go |=> (now_sec == $past(sec_stage) && now_tick == $past(tick_stage)));

    // R9
    load_once_chk: assert property (@(posedge clk) disable iff (rst)
        (load_go && !sec_wr) |=> !load_go);

    // R4
    imm_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_wr && imm_q) |=> load_go);

    // R8
    cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !edge_evt |=> ($stable(cap_sec) && $stable(cap_tick)));
endmodule

bind pps_timekeeper tk_checker #(.DATA_W(DATA_W)) u_tk_chk (
    .clk(clk), .rst(rst), .load_go(load_go), .edge_evt(edge_evt),
    .sec_wr(sec_wr), .imm_q(imm_q), .wrap_q(wrap_q),
    .sec_stage(sec_stage), .tick_stage(tick_stage),
    .now_sec(now_sec), .now_tick(now_tick),
    .cap_sec(cap_sec), .cap_tick(cap_tick)
);

// File: tb/pps_timekeeper_test.sv
module pps_timekeeper_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_data = '0;
    logic        pps_in = 1'b0;
    logic [31:0] now_sec, now_tick, cap_sec, cap_tick;

    int errors = 0;
    int checks = 0;
    longint ld_s, ld_t, wrap_cur, n;

    always #2 clk = ~clk;

    pps_timekeeper uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .pps_in(pps_in), .now_sec(now_sec),
        .now_tick(now_tick), .cap_sec(cap_sec), .cap_tick(cap_tick)
    );

    function automatic longint exp_tick();
        return (ld_t + n) % wrap_cur;
    endfunction
    function automatic longint exp_sec();
        return ld_s + (ld_t + n) / wrap_cur;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        n++;
    endtask

    task automatic chk_now(input string req);
        check(req, longint'(now_sec), exp_sec());
        check(req, longint'(now_tick), exp_tick());
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_idx = idx; cfg_data = d;
        step();
        cfg_wr = 1'b0;
    endtask

    // toggles pps, checks the three-clock latency, then load/capture result
    task automatic pps_toggle(input string req, input bit selected,
                              input bit loads, input longint s, input longint t);
        longint cs, ct, old_cs, old_ct;
        old_cs = cap_sec; old_ct = cap_tick;
        pps_in = ~pps_in;
        step(); chk_now({req, " R7 pre1"});
        step(); chk_now({req, " R7 pre2"});
        cs = exp_sec(); ct = exp_tick();
        step();
        if (loads) begin ld_s = s; ld_t = t; n = 0; end
        chk_now({req, " post"});
        if (selected) begin
            check({req, " R8 cap sec"}, longint'(cap_sec), cs);
            check({req, " R8 cap tick"}, longint'(cap_tick), ct);
        end else begin
            check({req, " R8 cap hold sec"}, longint'(cap_sec), old_cs);
            check({req, " R8 cap hold tick"}, longint'(cap_tick), old_ct);
        end
    endtask

    task automatic imm_load(input longint s, input longint t);
        wr(3'd3, 32'd1);
        wr(3'd1, 32'(t));
        wr(3'd0, 32'(s));
        ld_s = s; ld_t = t; n = -1;
    endtask

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        ld_s = 0; ld_t = 0; n = 0; wrap_cur = 100000000;
        repeat (3) @(negedge clk);
        check("R1 reset now_sec", longint'(now_sec), 0);
        check("R1 reset now_tick", longint'(now_tick), 0);
        check("R1 reset cap_sec", longint'(cap_sec), 0);
        check("R1 reset cap_tick", longint'(cap_tick), 0);
        rst = 1'b0;
        n = 0;
        for (int i = 0; i < 20; i++) begin step(); chk_now("R1 default count"); end

        // R3: unused indices must not disturb anything
        for (int k = 5; k < 8; k++) wr(3'(k), 32'h0000_0003);
        for (int i = 0; i < 4; i++) begin step(); chk_now("R3 unused index"); end

        // R2/R4 sweep over small wrap values and every start tick
        for (int w = 1; w <= 4; w++) begin
            wr(3'd4, 32'(w));
            wrap_cur = w;
            for (int t = 0; t < w; t++) begin
                imm_load(10 * w + t, t);
                step(); chk_now("R4 imm load");
                for (int i = 0; i < 2 * w + 2; i++) begin step(); chk_now("R2 wrap sweep"); end
            end
        end

        // R5/R6 falling edge, pending across rising edge
        wr(3'd4, 32'd1000); wrap_cur = 1000;
        imm_load(0, 0);
        wr(3'd3, 32'd0);
        wr(3'd2, 32'd0);
        wr(3'd1, 32'd7);
        wr(3'd0, 32'd500);
        for (int i = 0; i < 6; i++) begin step(); chk_now("R5 pending"); end
        pps_toggle("R6 rise unselected R5", 1'b0, 1'b0, 0, 0);
        for (int i = 0; i < 4; i++) begin step(); chk_now("R5 still pending"); end
        pps_toggle("R6 fall selected", 1'b1, 1'b1, 500, 7);
        // R9: second selected edge only captures
        pps_toggle("R9 rise unselected", 1'b0, 1'b0, 0, 0);
        pps_toggle("R9 fall capture only", 1'b1, 1'b0, 0, 0);

        // R6 rising edge selection
        wr(3'd2, 32'd1);
        wr(3'd1, 32'd0);
        wr(3'd0, 32'd900);
        pps_toggle("R6 rise selected", 1'b1, 1'b1, 900, 0);
        pps_toggle("R6 fall unselected", 1'b0, 1'b0, 0, 0);

        // R10 rewrite while pending
        wr(3'd1, 32'd5);
        wr(3'd0, 32'd111);
        wr(3'd0, 32'd222);
        for (int i = 0; i < 3; i++) begin step(); chk_now("R10 pending"); end
        pps_toggle("R10 newer value", 1'b1, 1'b1, 222, 5);
        for (int i = 0; i < 5; i++) begin step(); chk_now("R2 after pulse load"); end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule